// File: doc/BRIEF.md
# One-Bit Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an asynchronous static RAM that stores one bit per location. The RAM has an 18-bit address, a data input pin and a separate data output pin, and two active-low strobes: chip select and write strobe. The host issues single-bit read or write requests. The sequencer turns each request into a strobe pattern whose phases are long enough for the selected speed grade. For a read, it samples the RAM output once the access time has passed and returns the bit with a one-clock valid pulse.

Every phase length is computed at elaboration. The computation uses two parameters: the clock period in nanoseconds and a speed-grade index. Grade 0 is the 35 ns part and grade 1 is the 45 ns part. Each nanosecond limit is divided by the clock period, rounded up, and given a floor of one clock. Writes are ended by the write strobe while chip select is held low.

A retention input parks the RAM deselected so that its supply can be lowered. After the input is released, the sequencer holds the host off for one full read-cycle time.

Top module: `sram1b_ctrl`

## Requirements
- R1: A read drives chip select low with the write strobe high. It samples the RAM output at the clock edge that ends the read phase, which lasts N_RD = max(ceil(tAA/CLK_NS), ceil(tRC/CLK_NS)) clocks. It then raises `rvalid` for exactly one clock, with the sampled bit on `rdata`.
- R2: Whenever `ready` is high, both `sram_ce_n` and `sram_we_n` are high, so the RAM sits in standby.
- R3: A write holds `sram_we_n` low for exactly N_WP clocks. N_WP is the largest of ceil(tWP/CLK_NS), ceil(tDS/CLK_NS)-1, ceil(tCW/CLK_NS)-1 and ceil(tAW/CLK_NS)-1, and is at least 1. The RAM stores `req_wdata` at the requested address.
- R4: `sram_addr` and `sram_d` are driven one clock before the write strobe falls. They do not change while the strobe is low, nor during the clock after it rises. The address therefore meets the tAH hold time and the data meets the tDS setup time.
- R5: `sram_we_n` is never low while `sram_ce_n` is high.
- R6: With grade 0 the limits are: tAA = tRC = tWC = 35 ns, tWP = tCW = tAW = 30 ns, tDS = 20 ns and tAH = 5 ns. With grade 1 they are 45, 40, 20 and 5 ns. A write occupies 1 + N_WP + N_HOLD clocks, where N_HOLD = max(ceil(tAH/CLK_NS), ceil(tWC/CLK_NS)-1-N_WP, 1).
- R7: `ready` falls at the clock edge that accepts a request. It stays low until the access completes. A `req` seen while `ready` is low has no effect on the RAM.
- R8: `ret_req` seen while `ready` is high parks the sequencer. While parked, `sram_ce_n` stays high, `ready` stays low and requests are refused.
- R9: After `ret_req` falls, `ready` returns exactly N_REC = ceil(tRC/CLK_NS) clocks after the edge that sees the release.
- R10: While `rst_n` is low, and after it is released: `ready` = 1, `rvalid` = 0, `sram_ce_n` = 1 and `sram_we_n` = 1.
- R11: If `ret_req` and `req` are both high in an idle cycle, retention wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken only while `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Bit address |
| req_wdata | input | 1 | Bit to write |
| ret_req | input | 1 | Retention (park) request |
| ready | output | 1 | Idle and able to accept a request |
| rvalid | output | 1 | One-clock read-data valid |
| rdata | output | 1 | Bit returned by a read |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_d | output | 1 | RAM data input pin |
| sram_q | input | 1 | RAM data output pin |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |

## Verification
The assertions assume that the host raises `req` only while `ready` is high, except for deliberate probes of the refusal path. They also assume that `ret_req` only rises or falls between accesses. The bench waits for `ready` before every request and changes `ret_req` only on idle or parked cycles.

The RAM model in the bench returns the inverted bit whenever it is read before the access time has elapsed. This makes early sampling show up as wrong read data. The model also times each write-strobe pulse, the data setup and the address hold in nanoseconds, measured against grade-0 limits.

// File: rtl/sram1b_pkg.sv
`timescale 1ns/1ps
package sram1b_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_WSET, ST_WLOW, ST_WHOLD, ST_PARK, ST_RECOV
   } seq_st_e;

   // nanosecond limits, index 0 = fast grade, 1 = slow grade
   function automatic int unsigned lim_ns(input int unsigned grade, input int unsigned fast_ns,
                                          input int unsigned slow_ns);
      return (grade == 0) ? fast_ns : slow_ns;
   endfunction

   function automatic int unsigned ns2clk(input int unsigned ns, input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
      return (a > b + 1) ? a - b : 1;
   endfunction

endpackage

// File: rtl/sram1b_phase_cnt.sv
`timescale 1ns/1ps
module sram1b_phase_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram1b_fsm.sv
`timescale 1ns/1ps
module sram1b_fsm
   import sram1b_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned N_RD   = 2,
   parameter int unsigned N_WP   = 2,
   parameter int unsigned N_HOLD = 1,
   parameter int unsigned N_REC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_wr,
   input  logic             ret_req,
   input  logic             cnt_done,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output logic             accept,
   output logic             sample,
   output logic             ready,
   output logic             ce_n,
   output logic             we_n
);
   seq_st_e st_q;

   assign accept = (st_q == ST_IDLE) && !ret_req && req;
   assign sample = (st_q == ST_RD) && cnt_done;
   assign ready  = (st_q == ST_IDLE);

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (st_q)
         ST_IDLE:  if (accept && !req_wr) begin cnt_load = 1'b1; cnt_val = CNT_W'(N_RD - 1); end
         ST_WSET:  begin cnt_load = 1'b1; cnt_val = CNT_W'(N_WP - 1); end
         ST_WLOW:  if (cnt_done) begin cnt_load = 1'b1; cnt_val = CNT_W'(N_HOLD - 1); end
         ST_PARK:  if (!ret_req) begin cnt_load = 1'b1; cnt_val = CNT_W'(N_REC - 1); end
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ce_n <= 1'b1;
         we_n <= 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (ret_req)
                  st_q <= ST_PARK;
               else if (req) begin
                  ce_n <= 1'b0;
                  st_q <= req_wr ? ST_WSET : ST_RD;
               end
            end
            ST_RD:    if (cnt_done) begin ce_n <= 1'b1; st_q <= ST_IDLE; end
            ST_WSET:  begin we_n <= 1'b0; st_q <= ST_WLOW; end
            ST_WLOW:  if (cnt_done) begin we_n <= 1'b1; st_q <= ST_WHOLD; end
            ST_WHOLD: if (cnt_done) begin ce_n <= 1'b1; st_q <= ST_IDLE; end
            ST_PARK:  if (!ret_req) st_q <= ST_RECOV;
            ST_RECOV: if (cnt_done) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   we_low_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);

   // R8
   park_keeps_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && ce_n) |=> ce_n);
endmodule

// File: rtl/sram1b_qcap.sv
`timescale 1ns/1ps
module sram1b_qcap (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic q,
   output logic rvalid,
   output logic rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= 1'b0;
      end else begin
         rvalid <= sample;
         if (sample) rdata <= q;
      end
   end

   // R1
   rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);
endmodule

// File: rtl/sram1b_ctrl.sv
`timescale 1ns/1ps
module sram1b_ctrl
   import sram1b_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned CLK_NS = 20,
   parameter int unsigned GRADE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wdata,
   input  logic              ret_req,
   output logic              ready,
   output logic              rvalid,
   output logic              rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_d,
   input  logic              sram_q,
   output logic              sram_ce_n,
   output logic              sram_we_n
);
   localparam int unsigned T_RC = lim_ns(GRADE, 35, 45);
   localparam int unsigned T_AA = lim_ns(GRADE, 35, 45);
   localparam int unsigned T_WC = lim_ns(GRADE, 35, 45);
   localparam int unsigned T_WP = lim_ns(GRADE, 30, 40);
   localparam int unsigned T_CW = lim_ns(GRADE, 30, 40);
   localparam int unsigned T_AW = lim_ns(GRADE, 30, 40);
   localparam int unsigned T_DS = 20;
   localparam int unsigned T_AH = 5;

   localparam int unsigned N_RD   = max2(ns2clk(T_AA, CLK_NS), ns2clk(T_RC, CLK_NS));
   localparam int unsigned N_WP   = max2(max2(ns2clk(T_WP, CLK_NS), sub_floor1(ns2clk(T_DS, CLK_NS), 1)),
                                         max2(sub_floor1(ns2clk(T_CW, CLK_NS), 1),
                                              sub_floor1(ns2clk(T_AW, CLK_NS), 1)));
   localparam int unsigned N_HOLD = max2(ns2clk(T_AH, CLK_NS), sub_floor1(ns2clk(T_WC, CLK_NS), 1 + N_WP));
   localparam int unsigned N_REC  = ns2clk(T_RC, CLK_NS);
   localparam int unsigned N_MAX  = max2(max2(N_RD, N_WP), max2(N_HOLD, N_REC));
   localparam int unsigned CNT_W  = (N_MAX < 2) ? 1 : $clog2(N_MAX);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram1b_ctrl: ADDR_W must be at least 1");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram1b_ctrl: CLK_NS must be at least 1");
   end
   if (GRADE > 1) begin : g_bad_grade
      $error("sram1b_ctrl: GRADE must be 0 or 1");
   end

   logic             cnt_load, cnt_done, accept, sample;
   logic [CNT_W-1:0] cnt_val;

   sram1b_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
   );

   sram1b_fsm #(
      .CNT_W(CNT_W), .N_RD(N_RD), .N_WP(N_WP), .N_HOLD(N_HOLD), .N_REC(N_REC)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .ret_req(ret_req),
      .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_val(cnt_val), .accept(accept),
      .sample(sample), .ready(ready), .ce_n(sram_ce_n), .we_n(sram_we_n)
   );

   sram1b_qcap qcap_i (
      .clk(clk), .rst_n(rst_n), .sample(sample), .q(sram_q), .rvalid(rvalid), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sram_addr <= '0;
         sram_d    <= 1'b0;
      end else if (accept) begin
         sram_addr <= req_addr;
         sram_d    <= req_wdata;
      end
   end

   // R2
   idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sram_ce_n && sram_we_n));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n || !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_d)));

   // R7
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !sram_ce_n) |=> $stable(sram_addr));
endmodule

// File: tb/sram1b_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram1b_ctrl_tb_top;
   localparam int CLK_NS = 20;
   // grade-0 limits in ns
   localparam int T_AA = 35, T_RC = 35, T_WC = 35, T_WP = 30, T_CW = 30, T_AW = 30, T_DS = 20, T_AH = 5;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int B_RD   = mx(cdiv(T_AA), cdiv(T_RC));
   localparam int B_WP   = mx(mx(cdiv(T_WP), mx(cdiv(T_DS) - 1, 1)), mx(cdiv(T_CW) - 1, cdiv(T_AW) - 1));
   localparam int B_HOLD = mx(mx(cdiv(T_AH), cdiv(T_WC) - 1 - B_WP), 1);
   localparam int B_WLEN = 1 + B_WP + B_HOLD;
   localparam int B_REC  = cdiv(T_RC);

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req = 1'b0, req_wr = 1'b0, req_wdata = 1'b0, ret_req = 1'b0;
   logic [17:0] req_addr = '0;
   logic        ready, rvalid, rdata, sram_d, sram_ce_n, sram_we_n;
   logic        sram_q = 1'b0;
   logic [17:0] sram_addr;

   int  n_checks = 0, n_errors = 0;
   bit  run = 1'b0, finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   sram1b_ctrl #(.ADDR_W(18), .CLK_NS(CLK_NS), .GRADE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .ret_req(ret_req), .ready(ready), .rvalid(rvalid), .rdata(rdata),
      .sram_addr(sram_addr), .sram_d(sram_d), .sram_q(sram_q), .sram_ce_n(sram_ce_n),
      .sram_we_n(sram_we_n)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural RAM with timing monitors ----------------
   bit     ram [int];
   longint t_sel = 0, t_d = 0, t_addr = 0, t_wefall = 0, t_werise = -1000, t_cefall = 0;

   function automatic bit ram_rd(input int a);
      return ram.exists(a) ? ram[a] : 1'b0;
   endfunction

   always @(sram_addr or sram_ce_n) t_sel = $time;
   always @(sram_d) t_d = $time;
   always @(negedge sram_ce_n) t_cefall = $time;
   always @(negedge sram_we_n) t_wefall = $time;

   always @(sram_addr) begin
      t_addr = $time;
      if (run) begin
         // R4 address hold after the write strobe rises
         chk(sram_we_n == 1'b1, "R4 addr moved under low strobe", sram_we_n, 1);
         chk(($time - t_werise) >= T_AH, "R4 addr hold ns", $time - t_werise, T_AH);
      end
   end

   always @(posedge sram_we_n) begin
      if (run && !sram_ce_n) begin
         // R6 grade-0 write timing in ns
         chk(($time - t_wefall) >= T_WP, "R6 strobe width ns", $time - t_wefall, T_WP);
         chk(($time - t_d) >= T_DS, "R6 data setup ns", $time - t_d, T_DS);
         chk(($time - t_cefall) >= T_CW, "R6 select to end ns", $time - t_cefall, T_CW);
         chk(($time - t_addr) >= T_AW, "R6 addr to end ns", $time - t_addr, T_AW);
         ram[int'(sram_addr)] = sram_d;
      end
      t_werise = $time;
   end

   // output is the inverted bit until the access time has elapsed
   always begin
      #1;
      if (!sram_ce_n && sram_we_n)
         sram_q = (($time - t_sel) >= T_AA) ? ram_rd(int'(sram_addr)) : ~ram_rd(int'(sram_addr));
   end

   // ---------------- cycle reference model ----------------
   bit ref_mem [int];
   int busy = 0;
   bit m_ret = 1'b0, pend = 1'b0, pend_val = 1'b0, exp_valid = 1'b0, exp_rdata = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         busy = 0; m_ret = 0; pend = 0; exp_valid = 0;
      end else begin
         exp_valid = 0;
         if (m_ret) begin
            if (!ret_req) begin m_ret = 0; busy = B_REC; end
         end else if (busy > 0) begin
            busy--;
            if (busy == 0 && pend) begin exp_valid = 1; exp_rdata = pend_val; pend = 0; end
         end else if (ret_req) begin
            m_ret = 1;
         end else if (req) begin
            if (req_wr) begin
               busy = B_WLEN;
               ref_mem[int'(req_addr)] = req_wdata;
            end else begin
               busy = B_RD; pend = 1;
               pend_val = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 1'b0;
            end
         end
      end
   end

   int we_run = 0;
   always @(negedge clk) begin
      if (run) begin
         // R7 ready tracks the model, R9 recovery included
         chk(ready == (!m_ret && busy == 0), "R7 ready", ready, !m_ret && busy == 0);
         chk(rvalid == exp_valid, "R1 rvalid", rvalid, exp_valid);
         if (exp_valid) chk(rdata == exp_rdata, "R1 rdata", rdata, exp_rdata);
         if (ready) chk(sram_ce_n && sram_we_n, "R2 idle pins", {sram_ce_n, sram_we_n}, 3);
         chk(sram_we_n || !sram_ce_n, "R5 strobe without select", {sram_ce_n, sram_we_n}, 0);
         if (m_ret) chk(sram_ce_n == 1'b1, "R8 parked select", sram_ce_n, 1);
         if (!sram_we_n) we_run++;
         else if (we_run != 0) begin
            chk(we_run == B_WP, "R3 strobe clocks", we_run, B_WP);
            we_run = 0;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit wr, input logic [17:0] a, input bit d);
      while (!ready) @(negedge clk);
      req = 1; req_wr = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 0;
   endtask

   task automatic rd_chk(input logic [17:0] a, input bit exp, input string tag);
      issue(0, a, 0);
      while (!rvalid) @(negedge clk);
      chk(rdata == exp, tag, rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values
      chk(ready == 1 && rvalid == 0, "R10 reset handshake", {ready, rvalid}, 2);
      chk(sram_ce_n == 1 && sram_we_n == 1, "R10 reset strobes", {sram_ce_n, sram_we_n}, 3);
      rst_n = 1;
      @(negedge clk);
      run = 1;
      chk(ready == 1 && sram_ce_n == 1, "R10 after release", {ready, sram_ce_n}, 3);

      // R3 writes of both values at edge addresses, R1 read-back
      issue(1, 18'h00000, 1);
      issue(1, 18'h3FFFF, 1);
      issue(1, 18'h12345, 0);
      issue(1, 18'h2AAAA, 1);
      rd_chk(18'h00000, 1, "R1 read addr 0");
      rd_chk(18'h3FFFF, 1, "R1 read top addr");
      rd_chk(18'h12345, 0, "R1 read zero bit");
      rd_chk(18'h2AAAA, 1, "R3 read alt addr");
      rd_chk(18'h15555, 0, "R1 unwritten addr");
      issue(1, 18'h3FFFF, 0);
      rd_chk(18'h3FFFF, 0, "R3 overwrite");

      // R7 request while busy is ignored
      issue(1, 18'h00100, 1);
      req = 1; req_wr = 1; req_addr = 18'h00200; req_wdata = 1;
      @(negedge clk);
      req = 0;
      rd_chk(18'h00200, 0, "R7 busy request dropped");
      rd_chk(18'h00100, 1, "R7 first request kept");

      // R8 park, refused request
      while (!ready) @(negedge clk);
      ret_req = 1;
      repeat (2) @(negedge clk);
      chk(ready == 0 && sram_ce_n == 1, "R8 parked", {ready, sram_ce_n}, 1);
      req = 1; req_wr = 1; req_addr = 18'h00300; req_wdata = 1;
      @(negedge clk);
      req = 0;
      repeat (3) @(negedge clk);
      chk(sram_ce_n == 1, "R8 select stays high", sram_ce_n, 1);
      // R9 recovery length
      ret_req = 0;
      begin
         int n = 0;
         do begin @(negedge clk); n++; end while (!ready && n < 50);
         chk(n == B_REC + 1, "R9 recovery clocks", n, B_REC + 1);
      end
      rd_chk(18'h00300, 0, "R8 parked request refused");

      // R11 retention wins over a simultaneous request
      while (!ready) @(negedge clk);
      ret_req = 1; req = 1; req_wr = 1; req_addr = 18'h00400; req_wdata = 1;
      @(negedge clk);
      req = 0;
      chk(ready == 0 && sram_ce_n == 1, "R11 parked not accessing", {ready, sram_ce_n}, 1);
      repeat (2) @(negedge clk);
      ret_req = 0;
      rd_chk(18'h00400, 0, "R11 request dropped");

      // mixed back-to-back pattern
      for (int i = 0; i < 8; i++) issue(1, 18'(i * 18'h01111), i[0] ^ i[2]);
      for (int i = 0; i < 8; i++) rd_chk(18'(i * 18'h01111), i[0] ^ i[2], "R1 pattern read");

      repeat (4) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * CLK_NS);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule